// File: doc/BRIEF.md
# Level-Masked Interrupt Controller

This block gathers sixteen maskable peripheral interrupt lines and one non-maskable line, and turns them into a single numeric request code for the processor. Each maskable line carries a programmable 3-bit priority level. A line is forwarded only when its level is strictly greater than a single, chip-wide mask level. A forwarded line produces code 16 plus its index. The non-maskable line always produces code 32. Any falling input returns the code to 0.

Software reaches the controller through a simple byte-wide register port. The port holds a pending-status word, in which a pending source reads as 0. It also holds the mask word and four level words, each of which carries the levels of four sources, one per byte lane. Inputs are compared against registered copies of themselves, so only rising and falling edges cause events. The code output is a registered value.

The maskable sources are indexed 0 to 15 in this order: external lines 1 to 7, DMA channels 3, 2, 1 and 0, serial channels 0 and 1, and timers 0, 1 and 2.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the status word becomes 0x0000FFFF, the mask word and all four level words become 0, the input history is cleared, and `code_out` becomes 0.
- R2: A rising edge on maskable source s clears bit s of the status word, so a pending source reads as 0. If a register write to the status word lands in the same cycle, the hardware clear wins for that bit.
- R3: The level of source s is bits [2:0] of byte lane s%4 of level word s/4. Bits [7:3] of that byte are stored but do not affect the level.
- R4: A maskable rising edge is forwarded only when the source's level, zero-extended, is strictly greater than the full 32-bit mask word. An equal level is not forwarded, and any set mask bit above bit 2 also blocks forwarding.
- R5: A forwarded maskable source s sets `code_out` to 16+s.
- R6: A rising edge on `nmi_in` sets `code_out` to 32, whatever the mask and level values are.
- R7: A falling edge on any input, maskable or not, sets `code_out` to 0. This takes precedence over any rising edge in the same cycle.
- R8: When several rising edges occur in one cycle, a non-maskable edge wins. Otherwise the lowest-indexed source that passes the level test wins, even if a lower-indexed rising source fails the test.
- R9: `code_out` changes only at the clock edge where an input edge is first seen, which is the first clock after the input changes. A held input produces no further events, and `code_out` otherwise keeps its value.
- R10: The byte address is {word index, lane}, with the word index in bits [4:2] and the lane in bits [1:0]. Word index 0 is status, 1 is mask, and 4 to 7 are level words 0 to 3. Any other index reads as 0 and ignores writes.
- R11: A write replaces only the addressed byte of the target word, and the other bytes keep their values. Reads return the addressed byte combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, restores register defaults |
| src_in | input | 16 | Maskable source lines, index 0 to 15 |
| nmi_in | input | 1 | Non-maskable source line |
| bus_addr | input | 5 | Byte address: word index [4:2], lane [1:0] |
| bus_we | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for `bus_addr` |
| code_out | output | 6 | Registered interrupt code (0, 16 to 31, or 32) |

## Verification
Every source is given the level equal to its index modulo 8, and the mask is set to 3. With these settings, a walk of input patterns separates the following cases: forwarded from blocked sources, a first edge from a held level, a fall from a rise in the same cycle, and the lowest rising source from the lowest eligible one. Directed patterns then vary the mask. They test a level equal to the mask and a mask with only a high bit set. They also rewrite a single level byte with junk in its upper bits and race a status write against a hardware clear. The register map is exercised by reading back neighbouring bytes, unmapped words and the reset defaults.

// File: rtl/lmic_pkg.sv
package lmic_pkg;
    parameter int NSRC   = 16;
    parameter int LVL_W  = 3;
    parameter int REG_W  = 32;
    parameter int BYTE_W = 8;
    parameter int CODE_W = 6;
    parameter int IDX_W  = 3;

    localparam int LANES      = REG_W / BYTE_W;
    localparam int LANE_W     = $clog2(LANES);
    localparam int ADDR_W     = IDX_W + LANE_W;
    localparam int NLVL_WORDS = NSRC / LANES;
    localparam int MASK_BASE  = 16;
    localparam int NMI_CODE   = 32;

    localparam logic [IDX_W-1:0] IDX_STATUS = 3'd0;
    localparam logic [IDX_W-1:0] IDX_MASK   = 3'd1;
    localparam int               IDX_LVL0   = 4;

    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [REG_W-1:0]  word_t;
    typedef logic [CODE_W-1:0] code_t;

    localparam word_t STATUS_RST = word_t'((64'd1 << NSRC) - 1);

    typedef struct packed {
        logic [NSRC-1:0] rise;
        logic [NSRC-1:0] fall;
        logic            nmi_rise;
        logic            nmi_fall;
    } edge_t;

    function automatic code_t src_code(input int idx);
        return code_t'(MASK_BASE + idx);
    endfunction

    function automatic word_t put_byte(input word_t w, input logic [LANE_W-1:0] lane,
                                       input logic [BYTE_W-1:0] b);
        word_t r;
        r = w;
        r[lane*BYTE_W +: BYTE_W] = b;
        return r;
    endfunction
endpackage

// File: rtl/lmic_edge.sv
module lmic_edge
    import lmic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_in,
    input  logic            nmi_in,
    output edge_t           ev
);
    logic [NSRC-1:0] src_q;
    logic            nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= '0;
            nmi_q <= 1'b0;
        end else begin
            src_q <= src_in;
            nmi_q <= nmi_in;
        end
    end

    always_comb begin
        ev.rise     = src_in & ~src_q;
        ev.fall     = src_q & ~src_in;
        ev.nmi_rise = nmi_in & ~nmi_q;
        ev.nmi_fall = nmi_q & ~nmi_in;
    end
endmodule

// File: rtl/lmic_regfile.sv
module lmic_regfile
    import lmic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic [NSRC-1:0]     hw_clear,
    output level_t [NSRC-1:0]   levels,
    output word_t               mask_o
);
    logic [IDX_W-1:0]  idx;
    logic [LANE_W-1:0] lane;
    word_t             status_q, mask_q, status_nx;
    word_t             lvl_q [NLVL_WORDS];
    word_t             rd_word;

    assign idx  = bus_addr[ADDR_W-1:LANE_W];
    assign lane = bus_addr[LANE_W-1:0];

    // software write first, then hardware clear wins on the same bit
    always_comb begin
        status_nx = status_q;
        if (bus_we && idx == IDX_STATUS)
            status_nx = put_byte(status_q, lane, bus_wdata);
        status_nx = status_nx & ~word_t'(hw_clear);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= STATUS_RST;
            mask_q   <= '0;
        end else begin
            status_q <= status_nx;
            if (bus_we && idx == IDX_MASK)
                mask_q <= put_byte(mask_q, lane, bus_wdata);
        end
    end

    for (genvar w = 0; w < NLVL_WORDS; w++) begin : g_lvl
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX_LVL0 + w);
        always_ff @(posedge clk) begin
            if (rst)
                lvl_q[w] <= '0;
            else if (bus_we && idx == MY_IDX)
                lvl_q[w] <= put_byte(lvl_q[w], lane, bus_wdata);
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_map
        assign levels[s] = lvl_q[s / LANES][(s % LANES) * BYTE_W +: LVL_W];
    end

    always_comb begin
        rd_word = '0;
        if (idx == IDX_STATUS)
            rd_word = status_q;
        else if (idx == IDX_MASK)
            rd_word = mask_q;
        else
            for (int w = 0; w < NLVL_WORDS; w++)
                if (idx == IDX_W'(IDX_LVL0 + w))
                    rd_word = lvl_q[w];
        bus_rdata = rd_word[lane*BYTE_W +: BYTE_W];
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/lmic_arbiter.sv
module lmic_arbiter
    import lmic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  edge_t             ev,
    input  level_t [NSRC-1:0] levels,
    input  word_t             mask,
    output code_t             code_out
);
    logic [NSRC-1:0] eligible;
    code_t           code_q, code_nx;

    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
        assign eligible[s] = ev.rise[s] && (word_t'(levels[s]) > mask);
    end

    always_comb begin
        code_nx = code_q;
        if ((|ev.fall) || ev.nmi_fall)
            code_nx = '0;
        else if (ev.nmi_rise)
            code_nx = code_t'(NMI_CODE);
        else
            for (int i = NSRC - 1; i >= 0; i--)
                if (eligible[i])
                    code_nx = src_code(i);
    end

    always_ff @(posedge clk) begin
        if (rst) code_q <= '0;
        else     code_q <= code_nx;
    end

    assign code_out = code_q;
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lmic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_in,
    input  logic              nmi_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic [CODE_W-1:0] code_out
);
    edge_t             ev;
    level_t [NSRC-1:0] levels;
    word_t             mask_w;

    lmic_edge u_edge (
        .clk(clk), .rst(rst), .src_in(src_in), .nmi_in(nmi_in), .ev(ev)
    );

    lmic_regfile u_rf (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_clear(ev.rise),
        .levels(levels), .mask_o(mask_w)
    );

    lmic_arbiter u_arb (
        .clk(clk), .rst(rst), .ev(ev), .levels(levels), .mask(mask_w),
        .code_out(code_out)
    );
endmodule

// File: rtl/lmic_checker.sv
module lmic_checker
    import lmic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [NSRC-1:0]   src_in,
    input logic              nmi_in,
    input logic [CODE_W-1:0] code_out,
    input word_t             status
);
    logic [NSRC-1:0] src_d;
    logic            nmi_d;
    logic [NSRC-1:0] up_c;
    logic            any_fall, any_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_d <= '0;
            nmi_d <= 1'b0;
        end else begin
            src_d <= src_in;
            nmi_d <= nmi_in;
        end
    end

    assign up_c     = src_in & ~src_d;
    assign any_fall = (|(src_d & ~src_in)) || (nmi_d && !nmi_in);
    assign any_rise = (|up_c) || (nmi_in && !nmi_d);

    AST_RESET_DEFAULTS: assert property (@(posedge clk)
        rst |=> (code_out == '0 && status == STATUS_RST)); // R1

    AST_PENDING_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (|up_c) |=> ((status & word_t'($past(up_c))) == '0)); // R2

    AST_NMI_CODE: assert property (@(posedge clk) disable iff (rst)
        (nmi_in && !nmi_d && !any_fall) |=> (code_out == code_t'(NMI_CODE))); // R6

    AST_FALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        any_fall |=> (code_out == '0)); // R7

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!any_fall && !any_rise) |=> $stable(code_out)); // R9

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (code_out == '0 || code_out == code_t'(NMI_CODE) || code_out[5:4] == 2'b01)); // R5
endmodule

bind lvl_irq_ctrl lmic_checker u_chk (
    .clk(clk), .rst(rst), .src_in(src_in), .nmi_in(nmi_in),
    .code_out(code_out), .status(u_rf.status_q)
);

// File: tb/tb_lvl_irq_ctrl.sv
`timescale 1ns/1ps
module tb_lvl_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_in = '0;
    logic        nmi_in = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [5:0]  code_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    lvl_irq_ctrl dut (
        .clk(clk), .rst(rst), .src_in(src_in), .nmi_in(nmi_in),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .code_out(code_out)
    );

    // {src[15:0], nmi, expected code[5:0]}; mask 3, level of source s = s % 8
    localparam int NVEC = 14;
    localparam logic [22:0] VEC [NVEC] = '{
        {16'h0010, 1'b0, 6'd20},  // R5 source 4 forwarded
        {16'h0010, 1'b0, 6'd20},  // R9 held
        {16'h0011, 1'b0, 6'd20},  // R4 source 0 blocked, hold
        {16'h0031, 1'b0, 6'd21},  // R5 source 5
        {16'h0021, 1'b0, 6'd0},   // R7 fall
        {16'h0021, 1'b1, 6'd32},  // R6
        {16'h0061, 1'b1, 6'd22},  // R5 source 6
        {16'h0061, 1'b0, 6'd0},   // R7 nmi fall
        {16'h0F61, 1'b0, 6'd0},   // R4 levels 0..3 blocked
        {16'hFF61, 1'b0, 6'd28},  // R8 lowest eligible of 12..15
        {16'hFF60, 1'b1, 6'd0},   // R7 fall beats nmi rise
        {16'hFF60, 1'b1, 6'd0},   // R9 held
        {16'hFF70, 1'b0, 6'd0},   // R7 fall beats rise
        {16'h0000, 1'b0, 6'd0}    // R7
    };

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // drive inputs at a falling edge, sample the code at the next falling edge
    task automatic step(input logic [15:0] s, input logic n, input logic [5:0] exp, input string req);
        @(negedge clk);
        src_in = s; nmi_in = n;
        @(negedge clk);
        check(req, {2'b00, code_out}, {2'b00, exp});
    endtask

    initial begin
        logic [7:0] rd;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1 defaults
        check("R1 code", {2'b00, code_out}, 8'h00);
        bus_read(5'd0, rd); check("R1 status b0", rd, 8'hFF);
        bus_read(5'd1, rd); check("R1 status b1", rd, 8'hFF);
        bus_read(5'd2, rd); check("R1 status b2", rd, 8'h00);

        for (int s = 0; s < 16; s++)
            bus_write(5'((4 + s / 4) * 4 + s % 4), 8'(s % 8));
        bus_write(5'd4, 8'h03);

        for (int i = 0; i < NVEC; i++)
            step(VEC[i][22:7], VEC[i][6], VEC[i][5:0], $sformatf("R5/R7/R8 vec %0d", i));

        // R2 pending bits 1,2,3,7 untouched
        bus_read(5'd0, rd); check("R2 status b0", rd, 8'h8E);
        bus_read(5'd1, rd); check("R2 status b1", rd, 8'h00);
        // R2 hardware clear beats same-cycle write
        @(negedge clk);
        src_in = 16'h0002; bus_addr = 5'd0; bus_wdata = 8'hFF; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        bus_read(5'd0, rd); check("R2 clear wins", rd, 8'hFD);
        check("R4 source 1 blocked", {2'b00, code_out}, 8'h00);

        // R10 map
        bus_read(5'd4, rd);  check("R10 mask read", rd, 8'h03);
        bus_read(5'd8, rd);  check("R10 unmapped read", rd, 8'h00);
        bus_write(5'd12, 8'h55);
        bus_read(5'd12, rd); check("R10 unmapped write dropped", rd, 8'h00);
        bus_read(5'd4, rd);  check("R10 mask untouched", rd, 8'h03);

        // R4 high mask bit blocks, equal level blocks
        step(16'h0002, 1'b1, 6'd32, "R6 nmi");
        bus_write(5'd5, 8'h01);
        step(16'h0082, 1'b1, 6'd32, "R4 mask bit 8 blocks level 7");
        bus_write(5'd5, 8'h00);
        bus_write(5'd4, 8'h07);
        step(16'h0002, 1'b1, 6'd0, "R7 source 7 fall");
        step(16'h0082, 1'b1, 6'd0, "R4 equal level blocked");
        bus_write(5'd4, 8'h03);
        step(16'h0002, 1'b1, 6'd0, "R7");
        step(16'h0082, 1'b1, 6'd23, "R5 source 7");

        // R3/R11 lane mapping and byte replace
        bus_write(5'd29, 8'hF9);
        step(16'h0002, 1'b1, 6'd0, "R7");
        step(16'h2002, 1'b1, 6'd0, "R3 upper bits ignored, level 1 blocked");
        bus_read(5'd29, rd); check("R11 byte kept", rd, 8'hF9);
        bus_read(5'd28, rd); check("R11 neighbour kept", rd, 8'h04);
        bus_write(5'd29, 8'h0E);
        step(16'h0002, 1'b1, 6'd0, "R7");
        step(16'h2002, 1'b1, 6'd29, "R3 source 13 level 6");

        // R8 lowest eligible beats lower blocked riser
        step(16'h6006, 1'b1, 6'd30, "R8 source 14 over blocked 2");
        step(16'h6006, 1'b1, 6'd30, "R9 hold");
        step(16'h0000, 1'b0, 6'd0, "R7");
        step(16'h8000, 1'b1, 6'd32, "R8 nmi beats source 15");

        // R1 reset restores defaults
        @(negedge clk); rst = 1'b1;
        bus_write(5'd4, 8'h05);
        @(negedge clk);
        check("R1 code reset", {2'b00, code_out}, 8'h00);
        bus_read(5'd4, rd);  check("R1 mask reset", rd, 8'h00);
        bus_read(5'd29, rd); check("R1 level reset", rd, 8'h00);
        bus_read(5'd0, rd);  check("R1 status reset", rd, 8'hFF);
        @(negedge clk);
        src_in = '0; nmi_in = 1'b0; rst = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule